// File: doc/BRIEF.md
# Trigger Latching Arbiter

This block sits in front of the first four conversion slots of an analog-to-digital converter. Trigger sources produce requests in bursts, and a converter that is still busy would drop any request arriving during a conversion. Each request is formed from a slot selection (the pre-trigger) and a trigger event. The slot selection comes from a timer mask or from a small software-written code. The event comes from a synchronous timer pulse or from the rising edge of an asynchronous external line.

Requests for slots 0 to 3 are held in one latch per slot. The arbiter hands them to the converter one at a time, and each waits for the converter's completion pulse before the next is issued. Slots 4 to 7 take no part in the latching. Their request pulses are passed straight through, one cycle after the trigger event.

Top module: `trig_latch_arbiter`

## Requirements
- R1: During reset and afterwards, with no trigger event, `conv_req` and `direct_trig` stay 0 and no conversion is requested.
- R2: A trigger event sets the latch of every slot 0..3 whose bit is set in the selected slot mask. A latch is set only by such an event, and every set latch is eventually issued as one `conv_req` pulse carrying its slot number on `conv_slot`.
- R3: For slots 4..7, `direct_trig[k]` pulses for one cycle, one clock after an event whose selected mask has bit 4+k set. These slots never produce `conv_req`.
- R4: `pre_sel` value 2 selects the software slot code `sw_pre`. The values 0, 1 and 3 select the timer mask `tmr_pre`, where bit n requests slot n. The unselected source has no effect.
- R5: A software code of 4+i (i = 0..3) requests slot i only, so code 4 requests slot 0. Codes 0..3 request nothing. The software source never pulses `direct_trig`.
- R6: When several latches are pending at the moment of issue, the lowest slot number is issued first.
- R7: `conv_req` is a single-cycle pulse. After an issue, no further `conv_req` appears until `conv_done` has been sampled high. The next issue comes at the earliest one cycle after that sample. A `conv_done` while nothing is outstanding is ignored.
- R8: A latch clears when its request is issued. A further event for a slot that is still pending is absorbed and yields no extra conversion. An event that arrives in the very cycle of issue re-arms the latch.
- R9: With `trig_sel` = 1, `ext_trig` passes through a two-stage synchroniser and a rising-edge detector. Each rising edge counts as exactly one event, however long the line stays high, and `tmr_trig` is ignored.
- R10: With `trig_sel` = 0, every clock cycle with `tmr_trig` high is one event, and `ext_trig` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 2 | Slot-mask source: 2 = software code, other values = timer mask |
| sw_pre | input | 3 | Software slot code: 4+i selects slot i, 0..3 select nothing |
| tmr_pre | input | 8 | Timer slot mask, bit n for slot n |
| trig_sel | input | 1 | Event source: 0 = timer pulse, 1 = external rising edge |
| tmr_trig | input | 1 | Synchronous timer event, active each high cycle |
| ext_trig | input | 1 | Asynchronous external trigger line |
| conv_done | input | 1 | Converter completion pulse |
| conv_req | output | 1 | One-cycle conversion request for a latched slot |
| conv_slot | output | 2 | Slot of the current request, valid with `conv_req` |
| direct_trig | output | 4 | Unlatched request pulses for slots 4..7 |

## Verification
The assertions assume that `tmr_trig`, `pre_sel`, `tmr_pre`, `sw_pre` and `conv_done` are synchronous to `clk`, and that a `conv_done` pulse while a conversion is outstanding means that conversion has finished. In the stimulus, the converter is modelled with a one-pulse completion after a latency of one to ten cycles from each observed `conv_req`. Extra completion pulses are injected only while the bench's own model shows no conversion outstanding. The external line toggles at arbitrary cycles, and the bench models its two synchroniser stages cycle for cycle.

// File: rtl/tla_pkg.sv
`timescale 1ns/1ps
package tla_pkg;

  // slot-mask source select; only PSEL_SW chooses the software code
  typedef enum logic [1:0] {
    PSEL_TMR_A = 2'd0,
    PSEL_TMR_B = 2'd1,
    PSEL_SW    = 2'd2,
    PSEL_TMR_C = 2'd3
  } pre_sel_e;

  typedef enum logic {
    TSRC_TMR = 1'b0,
    TSRC_EXT = 1'b1
  } trig_src_e;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_WAIT = 1'b1
  } arb_state_e;

  // true when software code 'code' addresses latched slot 'slot'
  function automatic logic sw_hits_slot(input int unsigned code,
                                        input int unsigned base,
                                        input int unsigned slot);
    return code == (base + slot);
  endfunction

  // index of the lowest set bit, 0 when none is set
  function automatic int unsigned lowest_one(input logic [31:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/tla_edge_sync.sv
`timescale 1ns/1ps
module tla_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tla_req_form.sv
`timescale 1ns/1ps
module tla_req_form
  import tla_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 8,
  parameter int unsigned LATCH_SLOTS = 4,
  parameter int unsigned SWP_W       = 3
) (
  input  logic [1:0]           pre_sel,
  input  logic [SWP_W-1:0]     sw_pre,
  input  logic [NUM_SLOTS-1:0] tmr_pre,
  input  logic                 trig_sel,
  input  logic                 tmr_trig,
  input  logic                 ext_rise,
  output logic                 evt_o,
  output logic [NUM_SLOTS-1:0] mask_o
);
  localparam int unsigned SWP_BASE = 2 ** (SWP_W - 1);

  logic [NUM_SLOTS-1:0] sw_mask;

  // software code reaches latched slots only
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sw
    if (i < LATCH_SLOTS) begin : g_lat
      assign sw_mask[i] = sw_hits_slot(32'(sw_pre), SWP_BASE, i);
    end else begin : g_dir
      assign sw_mask[i] = 1'b0;
    end
  end

  always_comb begin
    if (pre_sel_e'(pre_sel) == PSEL_SW) mask_o = sw_mask;
    else                                mask_o = tmr_pre;
  end

  assign evt_o = (trig_src_e'(trig_sel) == TSRC_EXT) ? ext_rise : tmr_trig;
endmodule

// File: rtl/tla_latch_arb.sv
`timescale 1ns/1ps
module tla_latch_arb
  import tla_pkg::*;
#(
  parameter int unsigned LATCH_SLOTS = 4,
  localparam int unsigned SLOT_W = (LATCH_SLOTS > 1) ? $clog2(LATCH_SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LATCH_SLOTS-1:0] set_vec,
  input  logic                   conv_done,
  output logic                   conv_req,
  output logic [SLOT_W-1:0]      conv_slot,
  output logic [LATCH_SLOTS-1:0] pend_o,
  output logic                   busy_o,
  output logic                   issue_o,
  output logic [SLOT_W-1:0]      issue_slot_o
);
  arb_state_e             state_q;
  logic [LATCH_SLOTS-1:0] pend_q;
  logic [LATCH_SLOTS-1:0] clr_vec;

  assign busy_o       = (state_q == ARB_WAIT);
  assign issue_o      = !busy_o && (pend_q != '0);
  assign issue_slot_o = SLOT_W'(lowest_one(32'(pend_q)));

  // one latch per slot; a new event wins over the clear of the same slot
  for (genvar i = 0; i < LATCH_SLOTS; i++) begin : g_latch
    assign clr_vec[i] = issue_o && (issue_slot_o == SLOT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= set_vec[i] | (pend_q[i] & ~clr_vec[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ARB_IDLE;
      conv_req  <= 1'b0;
      conv_slot <= '0;
    end else begin
      conv_req <= issue_o;
      if (issue_o) conv_slot <= issue_slot_o;
      case (state_q)
        ARB_IDLE: if (issue_o)   state_q <= ARB_WAIT;
        ARB_WAIT: if (conv_done) state_q <= ARB_IDLE;
        default:                 state_q <= ARB_IDLE;
      endcase
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/trig_latch_arbiter.sv
`timescale 1ns/1ps
module trig_latch_arbiter #(
  parameter int unsigned NUM_SLOTS   = 8,
  parameter int unsigned LATCH_SLOTS = 4,
  parameter int unsigned SWP_W       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DIRECT_SLOTS = NUM_SLOTS - LATCH_SLOTS,
  localparam int unsigned SLOT_W = (LATCH_SLOTS > 1) ? $clog2(LATCH_SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              pre_sel,
  input  logic [SWP_W-1:0]        sw_pre,
  input  logic [NUM_SLOTS-1:0]    tmr_pre,
  input  logic                    trig_sel,
  input  logic                    tmr_trig,
  input  logic                    ext_trig,
  input  logic                    conv_done,
  output logic                    conv_req,
  output logic [SLOT_W-1:0]       conv_slot,
  output logic [DIRECT_SLOTS-1:0] direct_trig
);
  // named internal events, also observed by the bound checker
  logic                    ext_rise;
  logic                    trig_evt;
  logic [NUM_SLOTS-1:0]    slot_mask;
  logic [LATCH_SLOTS-1:0]  set_vec;
  logic [LATCH_SLOTS-1:0]  pend_vec;
  logic                    arb_busy;
  logic                    arb_issue;
  logic [SLOT_W-1:0]       arb_slot;

  tla_edge_sync #(.STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rst_n(rst_n), .async_in(ext_trig), .rise_o(ext_rise)
  );

  tla_req_form #(
    .NUM_SLOTS(NUM_SLOTS), .LATCH_SLOTS(LATCH_SLOTS), .SWP_W(SWP_W)
  ) i_form (
    .pre_sel(pre_sel), .sw_pre(sw_pre), .tmr_pre(tmr_pre),
    .trig_sel(trig_sel), .tmr_trig(tmr_trig), .ext_rise(ext_rise),
    .evt_o(trig_evt), .mask_o(slot_mask)
  );

  assign set_vec = trig_evt ? slot_mask[LATCH_SLOTS-1:0] : '0;

  tla_latch_arb #(.LATCH_SLOTS(LATCH_SLOTS)) i_arb (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .conv_done(conv_done),
    .conv_req(conv_req), .conv_slot(conv_slot), .pend_o(pend_vec),
    .busy_o(arb_busy), .issue_o(arb_issue), .issue_slot_o(arb_slot)
  );

  // upper slots skip the latches: one registered pulse per event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) direct_trig <= '0;
    else        direct_trig <= trig_evt ? slot_mask[NUM_SLOTS-1:LATCH_SLOTS] : '0;
  end
endmodule

// File: rtl/tla_checker.sv
`timescale 1ns/1ps
module tla_checker #(
  parameter int unsigned LATCH_SLOTS  = 4,
  parameter int unsigned DIRECT_SLOTS = 4,
  localparam int unsigned SLOT_W = (LATCH_SLOTS > 1) ? $clog2(LATCH_SLOTS) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              pre_sel,
  input logic                    conv_req,
  input logic [SLOT_W-1:0]       conv_slot,
  input logic [DIRECT_SLOTS-1:0] direct_trig,
  input logic                    busy,
  input logic [LATCH_SLOTS-1:0]  pend,
  input logic [LATCH_SLOTS-1:0]  set_vec,
  input logic                    issue,
  input logic [SLOT_W-1:0]       issue_slot
);
  logic [LATCH_SLOTS-1:0] pend_prev;
  logic [LATCH_SLOTS-1:0] set_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_prev <= '0;
      set_prev  <= '0;
    end else begin
      pend_prev <= pend;
      set_prev  <= set_vec;
    end
  end

  function automatic logic [LATCH_SLOTS-1:0] below(input logic [SLOT_W-1:0] s);
    logic [LATCH_SLOTS-1:0] m;
    for (int i = 0; i < LATCH_SLOTS; i++) m[i] = (i < int'(s));
    return m;
  endfunction

  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !conv_req);

  assert_lowest_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (pend_prev[conv_slot] && ((pend_prev & below(conv_slot)) == '0)));

  assert_clear_on_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !set_vec[issue_slot]) |=> !pend[$past(issue_slot)]);

  assert_set_only_by_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~pend_prev & ~set_prev) == '0));

  assert_sw_not_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_trig != '0) |-> ($past(pre_sel) != 2'd2));
endmodule

bind trig_latch_arbiter tla_checker #(
  .LATCH_SLOTS(LATCH_SLOTS), .DIRECT_SLOTS(DIRECT_SLOTS)
) i_tla_checker (
  .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .conv_req(conv_req),
  .conv_slot(conv_slot), .direct_trig(direct_trig), .busy(arb_busy),
  .pend(pend_vec), .set_vec(set_vec), .issue(arb_issue), .issue_slot(arb_slot)
);

// File: tb/test_trig_latch_arbiter.sv
`timescale 1ns/1ps
module test_trig_latch_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pre_sel = 2'd0;
  logic [2:0] sw_pre = 3'd0;
  logic [7:0] tmr_pre = 8'd0;
  logic       trig_sel = 1'b0;
  logic       tmr_trig = 1'b0;
  logic       ext_trig = 1'b0;
  logic       conv_done = 1'b0;
  logic       conv_req;
  logic [1:0] conv_slot;
  logic [3:0] direct_trig;

  always #2.5 clk = ~clk;

  trig_latch_arbiter i_trig_latch_arbiter (
    .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .sw_pre(sw_pre),
    .tmr_pre(tmr_pre), .trig_sel(trig_sel), .tmr_trig(tmr_trig),
    .ext_trig(ext_trig), .conv_done(conv_done), .conv_req(conv_req),
    .conv_slot(conv_slot), .direct_trig(direct_trig)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench restatement of the slot-selection rules
  function automatic logic [7:0] exp_mask(input logic [1:0] sel, input logic [2:0] sw,
                                          input logic [7:0] tm);
    if (sel != 2'd2) return tm;
    case (sw)
      3'd4: return 8'h01;
      3'd5: return 8'h02;
      3'd6: return 8'h04;
      3'd7: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [1:0] exp_lowest(input logic [3:0] p);
    if (p[0]) return 2'd0;
    if (p[1]) return 2'd1;
    if (p[2]) return 2'd2;
    return 2'd3;
  endfunction

  // cycle model
  logic       m_s1, m_s2, m_s3, m_busy, m_req;
  logic [3:0] m_pend, m_dir;
  logic [1:0] m_slot;
  int         cyc = 0;

  always @(posedge clk) begin
    logic       rise, evt;
    logic [7:0] mk;
    logic [3:0] np;
    cyc++;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_busy = 0; m_req = 0;
      m_pend = 0; m_dir = 0; m_slot = 0;
    end else begin
      rise = m_s2 & ~m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_trig;
      evt = trig_sel ? rise : tmr_trig;
      mk = exp_mask(pre_sel, sw_pre, tmr_pre);
      m_dir = evt ? mk[7:4] : 4'd0;
      np = m_pend;
      m_req = 0;
      if (!m_busy && m_pend != 4'd0) begin
        m_slot = exp_lowest(m_pend);
        np[m_slot] = 1'b0;
        m_req = 1;
        m_busy = 1;
      end else if (m_busy && conv_done) begin
        m_busy = 0;
      end
      if (evt) np = np | mk[3:0];
      m_pend = np;
    end
  end

  // converter model and output monitor
  int   lat_fix = 0;
  bit   spur_en = 0;
  int   cnt = 0;
  int   hist[$];
  int   hcyc[$];
  int   dir_cnt = 0;
  logic [3:0] dir_last = 0;

  always @(negedge clk) begin
    conv_done = 1'b0;
    if (rst_n) begin
      chk(conv_req == m_req, "R7 request timing", int'(conv_req), int'(m_req));
      if (m_req) chk(conv_slot == m_slot, "R6 issued slot", int'(conv_slot), int'(m_slot));
      chk(direct_trig == m_dir, "R3 direct pulses", int'(direct_trig), int'(m_dir));
      if (conv_req) begin
        hist.push_back(int'(conv_slot));
        hcyc.push_back(cyc);
        cnt = (lat_fix > 0) ? lat_fix : 1 + int'($urandom % 6);
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) conv_done = 1'b1;
      end else if (spur_en && !m_busy && ($urandom % 16 == 0)) begin
        conv_done = 1'b1;
      end
      if (direct_trig != 4'd0) begin
        dir_cnt++;
        dir_last = direct_trig;
      end
    end
  end

  task automatic pulse(input logic [1:0] sel, input logic [7:0] tm, input logic [2:0] sw);
    @(negedge clk);
    pre_sel = sel; tmr_pre = tm; sw_pre = sw; tmr_trig = 1'b1;
    @(negedge clk);
    tmr_trig = 1'b0;
  endtask

  task automatic drain();
    repeat (80) @(negedge clk);
    hist.delete();
    hcyc.delete();
    dir_cnt = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (4) @(negedge clk);
    chk(conv_req == 1'b0, "R1 reset conv_req", int'(conv_req), 0);
    chk(direct_trig == 4'd0, "R1 reset direct", int'(direct_trig), 0);
    rst_n = 1'b1;
    lat_fix = 10;
    repeat (12) @(negedge clk);
    chk(hist.size() == 0, "R1 idle no request", hist.size(), 0);
    drain();

    // R5: code 4 picks slot 0; timer mask ignored (R4)
    pulse(2'd2, 8'hFF, 3'd4);
    repeat (20) @(negedge clk);
    chk(hist.size() == 1, "R5 one request", hist.size(), 1);
    if (hist.size() > 0) chk(hist[0] == 0, "R5 code4 slot", hist[0], 0);
    chk(dir_cnt == 0, "R5 sw no direct", dir_cnt, 0);
    drain();

    // R5: code below 4 requests nothing
    pulse(2'd2, 8'hFF, 3'd2);
    repeat (20) @(negedge clk);
    chk(hist.size() == 0, "R5 code2 none", hist.size(), 0);
    drain();

    // R4 and R6: timer mask 0x0A -> slots 1 then 3, 12 cycles apart (R7)
    pulse(2'd3, 8'h0A, 3'd4);
    repeat (40) @(negedge clk);
    chk(hist.size() == 2, "R4 two requests", hist.size(), 2);
    if (hist.size() == 2) begin
      chk(hist[0] == 1, "R6 first slot", hist[0], 1);
      chk(hist[1] == 3, "R6 second slot", hist[1], 3);
      chk(hcyc[1] - hcyc[0] == 12, "R7 gap", hcyc[1] - hcyc[0], 12);
    end
    drain();

    // R8: slot 1 re-requested while pending is absorbed
    pulse(2'd0, 8'h03, 3'd0);
    repeat (2) @(negedge clk);
    pulse(2'd0, 8'h02, 3'd0);
    repeat (40) @(negedge clk);
    chk(hist.size() == 2, "R8 absorbed", hist.size(), 2);
    drain();

    // R3: upper slots pulse directly
    pulse(2'd0, 8'hF0, 3'd0);
    repeat (5) @(negedge clk);
    chk(dir_cnt == 1, "R3 one direct pulse", dir_cnt, 1);
    chk(dir_last == 4'hF, "R3 direct value", int'(dir_last), 15);
    chk(hist.size() == 0, "R3 no conv_req", hist.size(), 0);
    drain();

    // R9: long external high gives one event; timer pulse ignored
    @(negedge clk);
    trig_sel = 1'b1; pre_sel = 2'd0; tmr_pre = 8'h04;
    ext_trig = 1'b1;
    pulse(2'd0, 8'h04, 3'd0);
    repeat (30) @(negedge clk);
    chk(hist.size() == 1, "R9 one per edge", hist.size(), 1);
    if (hist.size() > 0) chk(hist[0] == 2, "R9 slot", hist[0], 2);
    ext_trig = 1'b0;
    repeat (5) @(negedge clk);
    ext_trig = 1'b1;
    repeat (30) @(negedge clk);
    chk(hist.size() == 2, "R9 second edge", hist.size(), 2);
    ext_trig = 1'b0;
    drain();

    // R10: three high cycles -> issue then re-arm then absorb = 2 requests
    @(negedge clk);
    trig_sel = 1'b0; pre_sel = 2'd0; tmr_pre = 8'h01; tmr_trig = 1'b1;
    ext_trig = 1'b1;
    repeat (3) @(negedge clk);
    tmr_trig = 1'b0;
    ext_trig = 1'b0;
    repeat (40) @(negedge clk);
    chk(hist.size() == 2, "R10 per-cycle events", hist.size(), 2);
    drain();

    // random phase, model checked every cycle (R2)
    lat_fix = 0;
    spur_en = 1;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      tmr_trig = ($urandom % 6 == 0);
      tmr_pre  = 8'($urandom);
      sw_pre   = 3'($urandom);
      pre_sel  = 2'($urandom);
      if ($urandom % 200 == 0) trig_sel = ~trig_sel;
      if ($urandom % 7 == 0) ext_trig = ~ext_trig;
    end
    tmr_trig = 1'b0;
    trig_sel = 1'b0;
    spur_en = 0;
    repeat (100) @(negedge clk);
    chk(m_pend == 4'd0 && conv_req == 1'b0, "R2 all latches drained", int'(m_pend), 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule